// File: doc/BRIEF.md
# I2C Serial Clock Prescaler

This block turns a fast system clock into the timing grid an I2C master needs for its serial clock. Two programmable dividers sit in cascade: a small one of up to 4 and a larger one of up to 64. Each time both reach their terminal count, the block emits one phase tick. Twenty-two ticks make one serial-clock period, so the bus clock equals the input clock divided by 22·(A+1)·(B+1). The fastest rate is therefore the input clock over 22, and common settings target 100 kHz or 400 kHz.

A bit engine uses the phase tick, the running phase index and the once-per-period strobe to place its START, data and STOP edges. It uses the level indication to drive the bus clock pin. The two divider fields come straight from a control-register image. A new value takes effect only on a period boundary, or at once while the block is disabled, so a setting changed mid-period cannot shorten or stretch the current period.

Top module: `scl_prescaler`

## Requirements
- R1: During and after reset, with enable low, phase_tick and period_strobe are 0, phase is 0 and scl_high is 1.
- R2: While enabled with fixed settings, phase_tick is a single-cycle pulse repeating every (div_a+1)·(div_b+1) clock cycles; div_a is a 2-bit factor code (1 to 4) and div_b a 6-bit factor code (1 to 64).
- R3: With div_a=0 and div_b=0, phase_tick is high on every cycle and period_strobe repeats every 22 cycles, the fastest possible serial clock.
- R4: phase steps by one on each phase_tick, from 0 to 21 and then back to 0, and holds its value between ticks.
- R5: While enabled, scl_high is 0 for phases 0 to 10 and 1 for phases 11 to 21.
- R6: period_strobe pulses together with the phase_tick that wraps phase from 21 to 0, once every 22·(div_a+1)·(div_b+1) cycles.
- R7: A divider value changed while enabled has no effect on tick spacing until the next wrap, and applies from that wrap onward.
- R8: While enable is low, no tick or strobe is produced, phase is 0, scl_high is 1, and the divider inputs are taken over so they apply from the first enabled cycle.
- R9: With div_a=3 and div_b=63, one serial-clock period is 5632 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the prescaler; low holds it idle |
| div_a | input | 2 | First divider code, factor div_a+1 |
| div_b | input | 6 | Second divider code, factor div_b+1 |
| phase_tick | output | 1 | One-cycle pulse per phase step |
| period_strobe | output | 1 | One-cycle pulse at the 21-to-0 wrap |
| scl_high | output | 1 | Serial clock level: 1 high, 0 low |
| phase | output | 5 | Current phase index 0 to 21 |

## Verification
The delicate coincidence is a divider write that arrives while a period is running, set against the wrap edge where the new setting is taken over. The bench changes the divider fields at phase 5 of a running period. It then measures the next tick gap, which must still use the old factor. It also measures the first gap after the following strobe, which must use the new one. A behavioural model, built on one integer countdown rather than two counters, is compared with the outputs on every cycle. It therefore also judges the cycle where the strobe, the wrap and the update of the setting all fall together.

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int A_W    = 2,
  parameter int B_W    = 6,
  parameter int PHASES = 22
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [A_W-1:0]             div_a,
  input  logic [B_W-1:0]             div_b,
  output logic                       phase_tick,
  output logic                       period_strobe,
  output logic                       scl_high,
  output logic [$clog2(PHASES)-1:0]  phase
);
  localparam int PH_W = $clog2(PHASES);
  localparam int HALF = PHASES / 2;

  logic [A_W-1:0] cnt_a, lat_a;
  logic [B_W-1:0] cnt_b, lat_b;
  logic           run;

  wire a_tc = (cnt_a == lat_a);
  wire b_tc = (cnt_b == lat_b);
  wire step = en & a_tc & b_tc;
  wire last = (phase == PH_W'(PHASES - 1));
  wire wrap = step & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a         <= '0;
      cnt_b         <= '0;
      lat_a         <= '0;
      lat_b         <= '0;
      phase         <= '0;
      run           <= 1'b0;
      phase_tick    <= 1'b0;
      period_strobe <= 1'b0;
    end else begin
      run           <= en;
      phase_tick    <= step;
      period_strobe <= wrap;
      if (!en) begin
        cnt_a <= '0;
        cnt_b <= '0;
        phase <= '0;
        lat_a <= div_a;
        lat_b <= div_b;
      end else begin
        cnt_a <= a_tc ? '0 : cnt_a + 1'b1;
        if (a_tc) cnt_b <= b_tc ? '0 : cnt_b + 1'b1;
        if (step) phase <= last ? '0 : phase + 1'b1;
        if (wrap) begin
          lat_a <= div_a;
          lat_b <= div_b;
        end
      end
    end
  end

  assign scl_high = ~run | (phase >= PH_W'(HALF));
endmodule

// File: rtl/scl_prescaler_sva.sv
module scl_prescaler_sva #(
  parameter int PH_W = 5,
  parameter int HALF = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            phase_tick,
  input logic            period_strobe,
  input logic            scl_high,
  input logic [PH_W-1:0] phase
);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!phase_tick && !period_strobe && phase == '0 && scl_high));

  p_strobe_with_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |-> phase_tick);

  p_strobe_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |-> (phase == '0));

  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_tick && phase != '0) |-> $stable(phase));

  p_scl_low_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_tick && phase != '0 && phase < PH_W'(HALF)) |-> !scl_high);
endmodule

bind scl_prescaler scl_prescaler_sva #(.PH_W($clog2(PHASES)), .HALF(PHASES / 2)) u_sva (
  .clk(clk), .rst_n(rst_n), .en(en), .phase_tick(phase_tick),
  .period_strobe(period_strobe), .scl_high(scl_high), .phase(phase)
);

// File: tb/scl_prescaler_test.sv
module scl_prescaler_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] div_a = 2'd0;
  logic [5:0] div_b = 6'd0;
  logic       phase_tick, period_strobe, scl_high;
  logic [4:0] phase;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  scl_prescaler uut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_a(div_a), .div_b(div_b),
    .phase_tick(phase_tick), .period_strobe(period_strobe),
    .scl_high(scl_high), .phase(phase)
  );

  always #4 clk = ~clk;

  // behavioural reference: one countdown integer per phase step
  int m_left, m_ph, m_n;
  bit m_run, m_tick, m_str;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0; m_ph = 0; m_n = 1; m_run = 0; m_tick = 0; m_str = 0;
    end else begin
      m_run = en;
      if (!en) begin
        m_left = 0; m_ph = 0; m_tick = 0; m_str = 0;
        m_n = (int'(div_a) + 1) * (int'(div_b) + 1);
      end else if (m_left + 1 >= m_n) begin
        m_left = 0;
        m_tick = 1;
        m_str  = (m_ph == 21);
        if (m_ph == 21) begin
          m_ph = 0;
          m_n  = (int'(div_a) + 1) * (int'(div_b) + 1);
        end else m_ph = m_ph + 1;
      end else begin
        m_left = m_left + 1;
        m_tick = 0;
        m_str  = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase_tick == m_tick, "R2 R7 tick", phase_tick, m_tick);
      chk(period_strobe == m_str, "R6 strobe", period_strobe, m_str);
      chk(int'(phase) == m_ph, "R4 phase", phase, m_ph);
      chk(scl_high == (!m_run || m_ph >= 11), "R5 scl level", scl_high, (!m_run || m_ph >= 11));
    end
  end

  task automatic gap_tick(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!phase_tick);
  endtask

  task automatic gap_strobe(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!period_strobe);
  endtask

  task automatic restart(input logic [1:0] a, input logic [5:0] b);
    @(negedge clk);
    en = 1'b0; div_a = a; div_b = b;
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    chk(phase_tick == 0 && period_strobe == 0, "R1 reset pulses", phase_tick, 0);
    chk(scl_high == 1 && phase == 0, "R1 reset level", scl_high, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(scl_high == 1 && phase == 0 && !phase_tick, "R1 idle after reset", scl_high, 1);

    restart(2'd1, 6'd2);
    gap_tick(g);
    gap_tick(g);
    chk(g == 6, "R2 tick gap N=6", g, 6);
    gap_strobe(g);
    gap_strobe(g);
    chk(g == 132, "R6 period 22*6", g, 132);

    while (!(phase_tick && phase == 5)) @(negedge clk);
    div_a = 2'd2; div_b = 6'd4;
    gap_tick(g);
    chk(g == 6, "R7 old factor kept mid-period", g, 6);
    gap_strobe(g);
    gap_tick(g);
    chk(g == 15, "R7 new factor after wrap", g, 15);
    gap_strobe(g);
    gap_strobe(g);
    chk(g == 330, "R7 R6 period 22*15", g, 330);

    @(negedge clk);
    en = 1'b0; div_a = 2'd0; div_b = 6'd0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!phase_tick && !period_strobe && scl_high && phase == 0, "R8 disabled quiet",
          {phase_tick, period_strobe, scl_high}, 3'b001);
    end
    en = 1'b1;
    gap_tick(g);
    gap_tick(g);
    chk(g == 1, "R3 tick every cycle", g, 1);
    gap_strobe(g);
    gap_strobe(g);
    chk(g == 22, "R3 minimum period", g, 22);

    restart(2'd3, 6'd63);
    gap_tick(g);
    gap_tick(g);
    chk(g == 256, "R9 max tick gap", g, 256);
    gap_strobe(g);
    gap_strobe(g);
    chk(g == 5632, "R9 max period", g, 5632);

    restart(2'd0, 6'd1);
    gap_tick(g);
    gap_tick(g);
    chk(g == 2, "R8 divider taken while disabled", g, 2);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule